// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature measurement is taken. It holds the operating-mode and conversion-rate settings. From them it raises a one-cycle start pulse toward an external converter, waits for the converter's completion pulse, and stores the returned reading in the temperature register. On the same edge it pulses a completion strobe that the alert logic uses to run its limit comparison.

Three operating modes are supported. Shutdown takes no measurements. One-shot takes a single measurement and then drops back to shutdown by itself. Continuous measures at a fixed period, and a slow timebase tick sets that period. The live mode code is brought out for readback. A power-on reset or a general-call reset restores the defaults and starts a measurement at once.

Top module: `conv_sched`

## Requirements
- R1: A reset (`rst_n` low) clears the temperature register to zero, sets the mode code to continuous (`2'b10`) and sets the rate code to `2'b01`. The first clock edge after reset is released schedules a start, so `conv_start` is high in the cycle after that edge.
- R2: A `gc_reset` pulse has the same effect as R1, including the immediate start that follows it.
- R3: In continuous mode (mode code `2'b10` or `2'b11`), the ticks counted between two successive starts equal `BASE_TICKS` times 64, 16, 4 or 1 for rate codes `2'b00`, `2'b01`, `2'b10` and `2'b11`. A tick that arrives in a start cycle is not counted, and the period runs from one start to the next.
- R4: A rate write changes neither the mode nor the schedule directly. The next start comes when the ticks counted since the previous start reach the period of the new rate.
- R5: On the clock edge that samples `conv_done` high while a conversion is running, `temp_q` takes `conv_result` and `conv_cmpl` is high for exactly the following cycle. `temp_q` changes at no other time except a reset.
- R6: Writing mode code `2'b01` while idle in shutdown starts one conversion. `mode_rd` reads `2'b01` while that conversion runs and `2'b00` from the edge that completes it, and no further start follows.
- R7: Writing mode code `2'b00` while a conversion runs lets that conversion complete and report. No start follows while the mode stays `2'b00`.
- R8: Writing `2'b01` while a conversion is already running holds the one-shot. A new start follows directly after the running conversion completes, and the mode reads `2'b00` only after that second conversion completes.
- R9: Writing a continuous code while the mode is shutdown starts a conversion in the cycle after the write.
- R10: `conv_start` is never high for two cycles in a row, and it never rises while an earlier conversion is still awaiting `conv_done`.
- R11: `temp_q` reads zero from reset until the first conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gc_reset | input | 1 | Synchronous general-call reset pulse, active high |
| tick | input | 1 | One-cycle timebase pulse; `BASE_TICKS` ticks make 1/16 s |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Mode code to write |
| cfg_rate | input | 2 | Rate code to write |
| conv_done | input | 1 | Converter completion pulse |
| conv_result | input | TEMP_W | Converter reading, valid with `conv_done` |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_cmpl | output | 1 | One-cycle pulse after the temperature register updates |
| temp_q | output | TEMP_W | Temperature register |
| mode_rd | output | 2 | Live mode code for readback |

## Verification
The hardest case to reach is a one-shot request that arrives while a continuous conversion is still running. The request has to land inside the few cycles between a start pulse and the converter's answer. The stimulus waits for `conv_start` at the ports and writes the one-shot code one cycle later, while the modelled converter is still counting its fixed latency. The same timing is used to switch to shutdown in the middle of a conversion. In both cases the bench checks that the pending completion is still reported and that the next start happens, or does not happen, as required.

// File: rtl/conv_sched_pkg.sv
// Package: shared phase type and code values for the conversion scheduler.
// Assumes the two-bit mode and rate codes used at the configuration port.
package conv_sched_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LAUNCH = 2'd1,
        PH_BUSY   = 2'd2
    } phase_t;

    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_ONCE = 2'b01;
    localparam logic [1:0] MODE_RUN  = 2'b10;
    localparam logic [1:0] RATE_DEF  = 2'b01;

endpackage

// File: rtl/cs_mode_ctrl.sv
// Mode and rate holder. It applies configuration writes and keeps a
// pending-start flag for one-shot requests and for entry into continuous mode.
// Assumes: take_kick and retire_once come from the phase sequencer in the
// same cycle, and are derived from the combinational next values given here.
module cs_mode_ctrl
    import conv_sched_pkg::*;
(
    input  logic       clk,
    input  logic       srst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_mode,
    input  logic [1:0] cfg_rate,
    input  logic       take_kick,
    input  logic       retire_once,
    output logic [1:0] mode_nx,
    output logic       kick_nx,
    output logic [1:0] mode_q,
    output logic [1:0] rate_q
);
    logic kick_q;

    // Work out the mode and pending flag that follow this cycle's write.
    always_comb begin
        mode_nx = mode_q;
        kick_nx = kick_q;
        if (cfg_wr) begin
            mode_nx = cfg_mode;
            unique case (cfg_mode)
                MODE_OFF:  kick_nx = 1'b0;
                MODE_ONCE: kick_nx = 1'b1;
                default:   kick_nx = kick_q | ~mode_q[1];
            endcase
        end
    end

    // Register the mode, the pending flag and the rate.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            mode_q <= MODE_RUN;
            kick_q <= 1'b1;
            rate_q <= RATE_DEF;
        end else begin
            mode_q <= retire_once ? MODE_OFF : mode_nx;
            kick_q <= kick_nx & ~take_kick;
            if (cfg_wr) begin
                rate_q <= cfg_rate;
            end
        end
    end

endmodule

// File: rtl/cs_period_timer.sv
// Period timer. It counts timebase ticks since the last start and flags
// when the period for the current rate code has been reached.
// Assumes: restart is high in the start cycle only; the count saturates at
// the longest period.
module cs_period_timer #(
    parameter int unsigned BASE_TICKS = 2
) (
    input  logic       clk,
    input  logic       srst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] rate,
    output logic       due
);
    localparam int unsigned MAXP = 64 * BASE_TICKS;
    localparam int unsigned CW   = $clog2(MAXP + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    // Map the rate code to a period in ticks.
    always_comb begin
        unique case (rate)
            2'b00:   limit = CW'(BASE_TICKS * 64);
            2'b01:   limit = CW'(BASE_TICKS * 16);
            2'b10:   limit = CW'(BASE_TICKS * 4);
            default: limit = CW'(BASE_TICKS);
        endcase
    end

    assign due = (cnt_q >= limit);

    // Count ticks since the last start, saturating at the longest period.
    always_ff @(posedge clk) begin
        if (!srst_n || restart) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != CW'(MAXP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cs_conv_fsm.sv
// Phase sequencer. It issues the start pulse, waits for the converter,
// captures the reading and decides whether the next conversion follows at once.
// Assumes: conv_done is only meaningful in the busy phase.
module cs_conv_fsm
    import conv_sched_pkg::*;
#(
    parameter int unsigned TEMP_W = 12
) (
    input  logic              clk,
    input  logic              srst_n,
    input  logic              kick_nx,
    input  logic [1:0]        mode_nx,
    input  logic              due,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] conv_result,
    output logic              conv_start,
    output logic              take_kick,
    output logic              retire_once,
    output logic [TEMP_W-1:0] temp_q,
    output logic              conv_cmpl
);
    phase_t ph_q, ph_nx;
    logic   periodic_go;

    assign periodic_go = mode_nx[1] & due;
    assign conv_start  = (ph_q == PH_LAUNCH);

    // Choose the next phase and the side effects on the mode holder.
    always_comb begin
        ph_nx       = ph_q;
        take_kick   = 1'b0;
        retire_once = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (kick_nx) begin
                    ph_nx     = PH_LAUNCH;
                    take_kick = 1'b1;
                end else if (periodic_go) begin
                    ph_nx = PH_LAUNCH;
                end
            end
            PH_LAUNCH: ph_nx = PH_BUSY;
            PH_BUSY: begin
                if (conv_done) begin
                    if (kick_nx) begin
                        ph_nx     = PH_LAUNCH;
                        take_kick = 1'b1;
                    end else if (periodic_go) begin
                        ph_nx = PH_LAUNCH;
                    end else begin
                        ph_nx       = PH_IDLE;
                        retire_once = (mode_nx == MODE_ONCE);
                    end
                end
            end
            default: ph_nx = PH_IDLE;
        endcase
    end

    // Register the phase, the captured reading and the completion strobe.
    always_ff @(posedge clk) begin
        if (!srst_n) begin
            ph_q      <= PH_IDLE;
            temp_q    <= '0;
            conv_cmpl <= 1'b0;
        end else begin
            ph_q      <= ph_nx;
            conv_cmpl <= (ph_q == PH_BUSY) && conv_done;
            if (ph_q == PH_BUSY && conv_done) begin
                temp_q <= conv_result;
            end
        end
    end

endmodule

// File: rtl/conv_sched.sv
// Conversion scheduler top. It joins the mode holder, the period timer and
// the phase sequencer. A general-call reset acts like the power-on reset.
// Assumes: every input is synchronous to clk; tick is a one-cycle pulse.
module conv_sched
    import conv_sched_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 2,
    parameter int unsigned TEMP_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gc_reset,
    input  logic              tick,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_rate,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] conv_result,
    output logic              conv_start,
    output logic              conv_cmpl,
    output logic [TEMP_W-1:0] temp_q,
    output logic [1:0]        mode_rd
);
    logic       srst_n;
    logic [1:0] mode_nx;
    logic       kick_nx;
    logic [1:0] rate_q;
    logic       take_kick;
    logic       retire_once;
    logic       due;

    assign srst_n = rst_n & ~gc_reset;

    cs_mode_ctrl i_mode (
        .clk         (clk),
        .srst_n      (srst_n),
        .cfg_wr      (cfg_wr),
        .cfg_mode    (cfg_mode),
        .cfg_rate    (cfg_rate),
        .take_kick   (take_kick),
        .retire_once (retire_once),
        .mode_nx     (mode_nx),
        .kick_nx     (kick_nx),
        .mode_q      (mode_rd),
        .rate_q      (rate_q)
    );

    cs_period_timer #(.BASE_TICKS(BASE_TICKS)) i_timer (
        .clk     (clk),
        .srst_n  (srst_n),
        .tick    (tick),
        .restart (conv_start),
        .rate    (rate_q),
        .due     (due)
    );

    cs_conv_fsm #(.TEMP_W(TEMP_W)) i_fsm (
        .clk         (clk),
        .srst_n      (srst_n),
        .kick_nx     (kick_nx),
        .mode_nx     (mode_nx),
        .due         (due),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .conv_start  (conv_start),
        .take_kick   (take_kick),
        .retire_once (retire_once),
        .temp_q      (temp_q),
        .conv_cmpl   (conv_cmpl)
    );

endmodule

// File: rtl/conv_sched_chk.sv
// Checker for the conversion scheduler, attached to the top through bind.
// It tracks on its own whether a conversion is outstanding at the ports.
module conv_sched_chk #(
    parameter int unsigned TEMP_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gc_reset,
    input logic              cfg_wr,
    input logic              conv_start,
    input logic              conv_done,
    input logic              conv_cmpl,
    input logic [TEMP_W-1:0] temp_q,
    input logic [1:0]        mode_rd
);
    logic outst;

    // Follow start and done pulses to know whether a conversion is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || gc_reset) begin
            outst <= 1'b0;
        end else if (conv_start) begin
            outst <= 1'b1;
        end else if (conv_done) begin
            outst <= 1'b0;
        end
    end

    a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n || gc_reset)
        conv_start |=> !conv_start);

    a_r10_single_flight: assert property (@(posedge clk) disable iff (!rst_n || gc_reset)
        conv_start |-> !outst);

    a_r5_done_reports: assert property (@(posedge clk) disable iff (!rst_n || gc_reset)
        (conv_done && outst) |=> conv_cmpl);

    a_r5_temp_only_on_cmpl: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(temp_q) && !$past(gc_reset)) |-> conv_cmpl);

    a_r7_off_no_start: assert property (@(posedge clk) disable iff (!rst_n || gc_reset)
        (mode_rd == 2'b00 && !cfg_wr) |=> !conv_start);

endmodule

bind conv_sched conv_sched_chk #(.TEMP_W(TEMP_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gc_reset   (gc_reset),
    .cfg_wr     (cfg_wr),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_cmpl  (conv_cmpl),
    .temp_q     (temp_q),
    .mode_rd    (mode_rd)
);

// File: tb/test_conv_sched.sv
module test_conv_sched;
    localparam int BASE = 2;
    localparam int TW   = 12;
    localparam int LAT  = 3;
    localparam int TDIV = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gc_reset = 1'b0;
    logic          tick = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_mode = 2'b00;
    logic [1:0]    cfg_rate = 2'b00;
    logic          conv_done = 1'b0;
    logic [TW-1:0] conv_result = '0;
    logic          conv_start;
    logic          conv_cmpl;
    logic [TW-1:0] temp_q;
    logic [1:0]    mode_rd;

    conv_sched #(.BASE_TICKS(BASE), .TEMP_W(TW)) i_conv_sched (
        .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset), .tick(tick),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
        .conv_done(conv_done), .conv_result(conv_result),
        .conv_start(conv_start), .conv_cmpl(conv_cmpl),
        .temp_q(temp_q), .mode_rd(mode_rd)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_all();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Timebase: one tick every TDIV cycles, changed just after the edge.
    int tdiv = 0;
    always @(posedge clk) begin
        #2;
        tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        tick = (tdiv == 0);
    end

    // Converter stand-in with a fixed latency, driven on falling edges.
    int cd = 0;
    int seq = 0;
    logic [TW-1:0] last_res = '0;
    always @(negedge clk) begin
        conv_done = 1'b0;
        if (gc_reset || !rst_n) begin
            cd = 0;
        end else begin
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    seq++;
                    conv_done   = 1'b1;
                    conv_result = TW'(seq * 403 + 12'h190);
                    last_res    = conv_result;
                end
            end
            if (conv_start) cd = LAT;
        end
    end

    // Behavioural reference, updated on every rising edge.
    int m_ph, m_pend, m_mode, m_rate, m_since, m_temp, m_cmpl;
    bit started = 0;
    int nm, np, per;
    bit due;
    always @(posedge clk) begin
        if (!rst_n || gc_reset) begin
            m_mode = 2; m_rate = 1; m_pend = 1; m_ph = 0;
            m_since = 0; m_temp = 0; m_cmpl = 0;
        end else begin
            per = BASE * ((m_rate == 0) ? 64 : (m_rate == 1) ? 16 : (m_rate == 2) ? 4 : 1);
            due = (m_since >= per);
            nm = m_mode; np = m_pend;
            if (cfg_wr) begin
                nm = int'(cfg_mode);
                if (cfg_mode == 2'b00) np = 0;
                else if (cfg_mode == 2'b01) np = 1;
                else if (m_mode < 2) np = 1;
            end
            if (m_ph == 1) m_since = 0;
            else if (tick && m_since < 64 * BASE) m_since++;
            m_cmpl = 0;
            case (m_ph)
                0: begin
                    if (np != 0) begin m_ph = 1; np = 0; end
                    else if (nm >= 2 && due) m_ph = 1;
                end
                1: m_ph = 2;
                default: begin
                    if (conv_done) begin
                        m_temp = int'(conv_result);
                        m_cmpl = 1;
                        if (np != 0) begin m_ph = 1; np = 0; end
                        else if (nm >= 2 && due) m_ph = 1;
                        else begin
                            m_ph = 0;
                            if (nm == 1) nm = 0;
                        end
                    end
                end
            endcase
            m_mode = nm; m_pend = np;
            if (cfg_wr) m_rate = int'(cfg_rate);
        end
        started = 1;
    end

    // Per-cycle comparison plus start-interval and event monitors.
    int since_t = 0;
    int last_iv = 0;
    int n_start = 0;
    int n_cmpl = 0;
    always @(negedge clk) begin
        if (started) begin
            chk("R10", "conv_start", int'(conv_start), (m_ph == 1) ? 1 : 0);
            chk("R5", "conv_cmpl", int'(conv_cmpl), m_cmpl);
            chk("R5", "temp_q", int'(temp_q), m_temp);
            chk("R6", "mode_rd", int'(mode_rd), m_mode);
        end
        if (conv_start) begin
            last_iv = since_t;
            since_t = 0;
            n_start++;
        end else if (tick) begin
            since_t++;
        end
        if (conv_cmpl) n_cmpl++;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wait_start(output int n);
        n = 0;
        do begin step(); n++; end while (!conv_start && n < 3000);
        if (n >= 3000) chk("R3", "start timeout", 0, 1);
    endtask

    task automatic wait_cmpl(output int n);
        n = 0;
        do begin step(); n++; end while (!conv_cmpl && n < 3000);
        if (n >= 3000) chk("R5", "completion timeout", 0, 1);
    endtask

    task automatic wr(input logic [1:0] md, input logic [1:0] rt);
        @(posedge clk); #2;
        cfg_wr = 1'b1; cfg_mode = md; cfg_rate = rt;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic idle_starts(input int cycles, output int cnt);
        int s0 = n_start;
        repeat (cycles) step();
        cnt = n_start - s0;
    endtask

    initial begin
        #(20 * 150000);
        chk("R1", "watchdog", 0, 1);
        finish_all();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        chk("R1", "temp after reset", int'(temp_q), 0);
        chk("R1", "mode after reset", int'(mode_rd), 2);
        step();
        chk("R1", "start after reset", int'(conv_start), 1);
        chk("R11", "temp before first result", int'(temp_q), 0);
        wait_cmpl(n);
        chk("R5", "temp holds reading", int'(temp_q), int'(last_res));

        // R3: default rate gives 16*BASE ticks between starts.
        wait_start(n);
        chk("R3", "interval rate 01", last_iv, 16 * BASE);
        wait_start(n);
        chk("R3", "interval rate 01 again", last_iv, 16 * BASE);

        // R4: rate change applies from the start after the write.
        wr(2'b10, 2'b10);
        wait_start(n);
        wait_start(n);
        chk("R4", "interval after rate change", last_iv, 4 * BASE);

        // R3 longest period.
        wr(2'b11, 2'b00);
        wait_start(n);
        wait_start(n);
        chk("R3", "interval rate 00", last_iv, 64 * BASE);

        // R7: shutdown requested mid-conversion.
        wr(2'b10, 2'b10);
        wait_start(n);
        wr(2'b00, 2'b10);
        wait_cmpl(n);
        chk("R7", "pending conversion still reports", (n <= LAT + 2) ? 1 : 0, 1);
        idle_starts(300, n);
        chk("R7", "no start in shutdown", n, 0);
        chk("R7", "mode reads shutdown", int'(mode_rd), 0);

        // R6: one-shot from shutdown.
        wr(2'b01, 2'b10);
        wait_start(n);
        chk("R6", "one-shot starts", (n <= 2) ? 1 : 0, 1);
        chk("R6", "mode during one-shot", int'(mode_rd), 1);
        wait_cmpl(n);
        chk("R6", "mode after one-shot", int'(mode_rd), 0);
        chk("R5", "one-shot reading", int'(temp_q), int'(last_res));
        idle_starts(200, n);
        chk("R6", "no start after one-shot", n, 0);

        // R9: continuous from shutdown starts next cycle.
        wr(2'b10, 2'b01);
        wait_start(n);
        chk("R9", "cycles to start", n, 1);

        // R8: one-shot written during a running conversion.
        wait_cmpl(n);
        wait_start(n);
        wr(2'b01, 2'b01);
        wait_cmpl(n);
        chk("R8", "held one-shot launches", int'(conv_start), 1);
        chk("R8", "mode while held one-shot", int'(mode_rd), 1);
        wait_cmpl(n);
        chk("R8", "mode after held one-shot", int'(mode_rd), 0);
        idle_starts(200, n);
        chk("R8", "no start afterwards", n, 0);

        // R2: general-call reset mid-run.
        wr(2'b10, 2'b11);
        repeat (40) step();
        @(posedge clk); #2 gc_reset = 1'b1;
        @(posedge clk); #2 gc_reset = 1'b0;
        step();
        chk("R2", "temp after general reset", int'(temp_q), 0);
        chk("R2", "mode after general reset", int'(mode_rd), 2);
        step();
        chk("R2", "start after general reset", int'(conv_start), 1);
        wait_start(n);
        chk("R2", "default rate restored", last_iv, 16 * BASE);
        repeat (20) step();
        finish_all();
    end
endmodule